// File: doc/BRIEF.md
# Dual-Channel Gain Code Register with Shared Serial/Parallel Pins

This block holds two 6-bit gain codes, one per channel, for a programmable-gain amplifier pair. Code 0 selects the lowest gain, and each code step adds a fixed fraction of a decibel. A mode pin selects how the codes are written. Both modes use the same six bus pins.

In parallel mode the bus carries a code directly. Each channel has its own load strobe, and raising both strobes writes one code into both channels. In serial mode three of the bus pins become a select, a data line and a shift clock. A single 12-bit frame carries both codes. The frame is committed to both channels in the same cycle when the select drops. A frame with the wrong length is dropped.

All pins are asynchronous to the system clock. They pass through two-flop synchronizers, and edges are found by comparing consecutive synchronized samples.

Top module: `dual_gain_port`

## Requirements
- R1: After reset both gain outputs are 0 and `frame_done` is 0.
- R2: `mode_pin` high selects serial mode and low selects parallel mode. In serial mode the two load strobes have no effect on either gain code.
- R3: In serial mode, bus bit 0 is the frame select (active high), bus bit 1 is serial data and bus bit 2 is the shift clock. Bus bits 3 to 5 are ignored.
- R4: A data bit is shifted in on each rising edge of the shift clock while the select is high.
- R5: Frame order: the first six bits shifted form the channel B code, least significant bit first. The next six bits form the channel A code, least significant bit first, so the last bit is the A MSB.
- R6: When the select falls after exactly 12 shift edges, both codes update in the same cycle and `frame_done` pulses high for exactly one clock.
- R7: If the select falls after any number of shift edges other than 12, both codes keep their previous values and `frame_done` stays low.
- R8: In parallel mode, the falling edge of the strobe for channel A or channel B loads the bus value into that channel and leaves the other channel unchanged.
- R9: In parallel mode, strobes for A and B that fall together load the same bus value into both channels.
- R10: A change of mode during a serial frame discards the bits shifted so far. A following frame of 12 bits is then accepted.
- R11: A pin edge reaches the outputs on the third rising system-clock edge after the pin changes: two synchronizer flops, then the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_pin | input | 1 | 1 = serial mode, 0 = parallel mode |
| bus_pin | input | 6 | Parallel code, or serial select/data/clock on bits 0/1/2 |
| load_a_pin | input | 1 | Channel A load strobe (parallel mode) |
| load_b_pin | input | 1 | Channel B load strobe (parallel mode) |
| gain_a | output | 6 | Channel A gain code |
| gain_b | output | 6 | Channel B gain code |
| frame_done | output | 1 | One-cycle pulse when a serial frame is committed |

## Verification
Every result comes three system clocks after the pin edge that causes it. The bench changes pins only on falling clock edges. It holds each pin level for four clocks and waits at least six clocks before it samples the gain codes. Samples are always taken on a falling edge, so no check sits on the edge where an output changes. `frame_done` is counted on every falling edge. After each frame, the change in that count must be exactly one for an accepted frame and zero for a dropped one.

// File: rtl/dual_gain_port.sv
module dual_gain_port #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_pin,
  input  logic [CODE_W-1:0] bus_pin,
  input  logic              load_a_pin,
  input  logic              load_b_pin,
  output logic [CODE_W-1:0] gain_a,
  output logic [CODE_W-1:0] gain_b,
  output logic              frame_done
);
  localparam int FRAME_W = 2 * CODE_W;
  localparam int PIN_W   = CODE_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic [PIN_W-1:0]   meta_q, sync_q, prev_q;
  logic [FRAME_W-1:0] shift_q;
  logic [CNT_W-1:0]   cnt_q;

  wire [PIN_W-1:0] pins = {load_b_pin, load_a_pin, mode_pin, bus_pin};
  wire [CODE_W-1:0] bus_s = sync_q[CODE_W-1:0];
  wire ser       = sync_q[CODE_W];
  wire mode_chg  = sync_q[CODE_W] != prev_q[CODE_W];
  wire sel       = sync_q[0];
  wire sel_fall  = ser && !mode_chg && prev_q[0] && !sync_q[0];
  wire sclk_rise = ser && sync_q[2] && !prev_q[2];
  wire a_fall    = !ser && !mode_chg && prev_q[CODE_W+1] && !sync_q[CODE_W+1];
  wire b_fall    = !ser && !mode_chg && prev_q[CODE_W+2] && !sync_q[CODE_W+2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= '0;
      sync_q     <= '0;
      prev_q     <= '0;
      shift_q    <= '0;
      cnt_q      <= '0;
      gain_a     <= '0;
      gain_b     <= '0;
      frame_done <= 1'b0;
    end else begin
      meta_q     <= pins;
      sync_q     <= meta_q;
      prev_q     <= sync_q;
      frame_done <= 1'b0;
      if (mode_chg || !sel) begin
        shift_q <= '0;
        cnt_q   <= '0;
      end else if (sclk_rise) begin
        shift_q <= {sync_q[1], shift_q[FRAME_W-1:1]};
        if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
      end
      if (sel_fall && cnt_q == CNT_FULL) begin
        gain_a     <= shift_q[FRAME_W-1:CODE_W];
        gain_b     <= shift_q[CODE_W-1:0];
        frame_done <= 1'b1;
      end
      if (a_fall) gain_a <= bus_s;
      if (b_fall) gain_b <= bus_s;
    end
  end

  AST_HOLD_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_fall || a_fall || b_fall) |=> $stable(gain_a) && $stable(gain_b)); // R8
  AST_DONE_SERIAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(ser)); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_OVER); // R7
  AST_MODE_CHG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> cnt_q == '0); // R10
endmodule

// File: tb/dual_gain_port_tb_top.sv
module dual_gain_port_tb_top;
  logic clk = 0, rst_n = 0;
  logic mode_p = 0, la_p = 0, lb_p = 0;
  logic [5:0] bus_p = '0;
  logic [5:0] gain_a, gain_b;
  logic frame_done;
  int checks = 0, fails = 0, fd_cnt = 0;
  logic [5:0] exp_a = '0, exp_b = '0;

  always #5 clk = ~clk;

  dual_gain_port dut_i (.clk(clk), .rst_n(rst_n), .mode_pin(mode_p), .bus_pin(bus_p),
    .load_a_pin(la_p), .load_b_pin(lb_p), .gain_a(gain_a), .gain_b(gain_b),
    .frame_done(frame_done));

  always @(negedge clk) if (frame_done) fd_cnt++;

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_gains(input string req);
    chk(req, gain_a, exp_a);
    chk(req, gain_b, exp_b);
  endtask

  task automatic ser_bit(input logic d, input int junk);
    bus_p = {3'(junk), 1'b0, d, 1'b1}; wt(4);
    bus_p[2] = 1'b1; wt(4);
    bus_p[2] = 1'b0; wt(4);
  endtask

  task automatic ser_frame(input logic [5:0] a, input logic [5:0] b, input int nbits);
    logic [11:0] word;
    word = {a, b};
    bus_p = 6'b000_001; wt(4);
    for (int i = 0; i < nbits; i++) ser_bit(word[i % 12], i * 3);
    bus_p = 6'b000_000; wt(6);
  endtask

  task automatic par_load(input logic [5:0] code, input logic a, input logic b);
    bus_p = code; wt(4);
    la_p = a; lb_p = b; wt(4);
    la_p = 0; lb_p = 0; wt(6);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int fd0;
    wt(3); rst_n = 1; wt(2);
    chk_gains("R1 reset");
    chk("R1 done", frame_done, 0);

    // R8 R9 parallel sweep of all codes
    mode_p = 0; wt(6);
    for (int c = 0; c < 64; c++) begin
      par_load(6'(c), 1, 0); exp_a = 6'(c);
      chk_gains("R8 load A");
      par_load(6'(63 - c), 0, 1); exp_b = 6'(63 - c);
      chk_gains("R8 load B");
      par_load(6'(c ^ 21), 1, 1); exp_a = 6'(c ^ 21); exp_b = 6'(c ^ 21);
      chk_gains("R9 load both");
    end
    par_load(6'd17, 1, 0); exp_a = 17;
    par_load(6'd40, 0, 1); exp_b = 40;
    chk_gains("R11 latency");

    // R11: output appears on third posedge after pin edge
    bus_p = 6'd9; wt(4); la_p = 1; wt(4);
    la_p = 0;
    @(negedge clk); @(negedge clk);
    chk("R11 not yet", gain_a, 17);
    @(negedge clk);
    chk("R11 due", gain_a, 9); exp_a = 9;

    // serial mode
    mode_p = 1; bus_p = 0; wt(6);
    for (int f = 0; f < 32; f++) begin
      fd0 = fd_cnt;
      exp_a = 6'((f * 5 + 3) % 64); exp_b = 6'((f * 11 + 60) % 64);
      ser_frame(exp_a, exp_b, 12);
      chk_gains("R4 R5 R6 serial frame");
      chk("R6 done pulse", fd_cnt - fd0, 1);
    end

    // R3 R7 short and long frames dropped
    fd0 = fd_cnt;
    ser_frame(6'd1, 6'd2, 11);
    chk_gains("R7 short frame");
    ser_frame(6'd1, 6'd2, 13);
    chk_gains("R7 long frame");
    chk("R7 no done", fd_cnt - fd0, 0);

    // R2 strobes ignored in serial mode
    bus_p = 6'b101_000; wt(4);
    la_p = 1; lb_p = 1; wt(4); la_p = 0; lb_p = 0; wt(6);
    chk_gains("R2 strobes ignored");

    // R10 mode change mid-frame clears partial bits
    fd0 = fd_cnt;
    bus_p = 6'b000_001; wt(4);
    for (int i = 0; i < 6; i++) ser_bit(1'b1, 0);
    mode_p = 0; wt(6); mode_p = 1; wt(6);
    exp_a = 6'd37; exp_b = 6'd26;
    for (int i = 0; i < 12; i++) ser_bit(i < 6 ? exp_b[i] : exp_a[i - 6], 7);
    bus_p = 0; wt(6);
    chk_gains("R10 frame after mode change");
    chk("R10 done", fd_cnt - fd0, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule